// File: doc/BRIEF.md
# Variable-Length Instruction Byte Parser

This block accepts machine-code bytes one at a time on a valid/ready input stream and splits them into instruction fields. Zero or more size-override prefixes may come first. Then comes the opcode, an optional addressing byte (mode/register/rm), an optional scale-index-base byte, and the displacement and immediate bytes in little-endian order. The parser works out how many bytes each optional field needs from the prefixes, the opcode and the addressing-mode bits. It never needs to look ahead.

When the final byte of an instruction has been accepted, the block emits a one-cycle decoded record. The record holds the field values, the total byte count, the effective operand and address sizes, and two error flags. The opcode set is small. It covers the register/memory move and add forms and the short move-immediate-to-register form. Any other opcode closes a record at once, so a downstream consumer keeps its byte alignment. Sizes default to 32 bits, and each prefix switches its size to 16 bits.

Top module: `ibp_top`

## Requirements
- R1: While reset is asserted, `in_ready` and `rec_valid` are 0. After release, `in_ready` is 1 and `rec_valid` stays 0 until an instruction completes. Reset in the middle of an instruction discards its partial state, including any prefix already seen.
- R2: Before the opcode, byte 0x66 forces a 16-bit full operand size and byte 0x67 forces 16-bit addressing (`rec_addr16`=1). Each works in either order, and every prefix byte counts toward `rec_len`. Without them both sizes are 32-bit.
- R3: Opcodes 0x00-0x03 and 0x88-0x8B take an addressing byte, split from bit 7 down as mod[1:0], reg[2:0], rm[2:0]. Opcode bit 0 selects byte width. `rec_opsize` encodes 0 = 8-bit, 1 = 16-bit, 2 = 32-bit.
- R4: With 32-bit addressing and no scale-index-base byte, the displacement length is: mod 00 with rm 101 gives 4 bytes, other mod 00 gives none, mod 01 gives 1, mod 10 gives 4, and mod 11 gives none.
- R5: With 32-bit addressing, rm 100 with mod other than 11 makes the next byte a scale-index-base byte, split from bit 7 down as scale[1:0], index[2:0], base[2:0]. In that case the displacement is 4 bytes when mod is 00 and base is 101, none for other mod 00, 1 byte for mod 01 and 4 bytes for mod 10.
- R6: With 16-bit addressing there is never a scale-index-base byte. mod 00 with rm 110 gives 2 displacement bytes, other mod 00 gives none, mod 01 gives 1, mod 10 gives 2 and mod 11 gives none.
- R7: `rec_bad_addr` is 1 exactly when a scale-index-base byte has index 100 and scale other than 00.
- R8: Opcodes 0xB0-0xBF are immediate moves with no addressing byte. `rec_reg` is opcode bits 2:0 and bit 3 is the width bit. The immediate is 1 byte when that bit is 0, and otherwise 2 bytes with 0x66 or 4 bytes without it.
- R9: Displacement and immediate are assembled least significant byte first and zero-extended to 32 bits. `rec_disp_bytes` and `rec_imm_bytes` give their lengths. Fields an instruction does not have read as 0.
- R10: Any other opcode byte ends the record at that byte with `rec_bad_opcode`=1. The length is the prefix count plus one, no field bytes are expected, and the operand size is the full width given by the prefixes.
- R11: `rec_valid` is a one-cycle pulse in the cycle after the final byte is accepted. Cycles with `in_valid` low consume nothing. The first byte of the next instruction may be accepted in the same cycle as the pulse.
- R12: The byte sequence 66 8B 04 4B gives length 4, opcode 0x8B, 16-bit operand, reg 000, mod 00, rm 100, scale 01, index 001, base 011 and no displacement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte present |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Parser can take a byte |
| rec_valid | output | 1 | Record pulse |
| rec_len | output | 5 | Total bytes including prefixes |
| rec_opcode | output | 8 | Opcode byte |
| rec_opsize | output | 2 | Effective operand size (0=8, 1=16, 2=32) |
| rec_addr16 | output | 1 | 16-bit addressing in effect |
| rec_has_modrm | output | 1 | Addressing byte present |
| rec_mod | output | 2 | mod field |
| rec_reg | output | 3 | reg field or short-form register |
| rec_rm | output | 3 | rm field |
| rec_has_sib | output | 1 | Scale-index-base byte present |
| rec_scale | output | 2 | Scale field |
| rec_index | output | 3 | Index field |
| rec_base | output | 3 | Base field |
| rec_disp_bytes | output | 3 | Displacement length in bytes |
| rec_disp | output | 32 | Displacement, zero-extended |
| rec_imm_bytes | output | 3 | Immediate length in bytes |
| rec_imm | output | 32 | Immediate, zero-extended |
| rec_bad_opcode | output | 1 | Unsupported opcode |
| rec_bad_addr | output | 1 | Undefined scale with no index |

## Verification
A wrong byte count in the parser shows up as soon as the record pulse arrives. The pulse comes one cycle early or late, the length is off, and from then on every later record is shifted by the same amount. This cascade makes length errors easy to spot within one or two instructions. A prefix flag that is not cleared, or a wrong scale-index-base decision, changes the size or field values in the very next record. The bench therefore compares whole records, feeds instructions back to back, inserts idle gaps filled with prefix-valued garbage, and resets in the middle of an instruction.

// File: rtl/ibp_pkg.sv
package ibp_pkg;

  localparam int LEN_W  = 5;
  localparam int DISP_W = 32;
  localparam int IMM_W  = 32;
  localparam int CNT_W  = 3;

  typedef enum logic [1:0] {SZ8 = 2'd0, SZ16 = 2'd1, SZ32 = 2'd2, SZ_NONE = 2'd3} sz_e;

  typedef enum logic [2:0] {
    ST_HEAD, ST_MODRM, ST_SIB, ST_DISP, ST_IMM
  } pstate_e;

  typedef struct packed {
    logic [LEN_W-1:0]  len;
    logic [7:0]        opcode;
    sz_e               opsize;
    logic              addr16;
    logic              has_modrm;
    logic [1:0]        mod;
    logic [2:0]        reg_f;
    logic [2:0]        rm;
    logic              has_sib;
    logic [1:0]        scale;
    logic [2:0]        index;
    logic [2:0]        base;
    logic [CNT_W-1:0]  disp_bytes;
    logic [DISP_W-1:0] disp;
    logic [CNT_W-1:0]  imm_bytes;
    logic [IMM_W-1:0]  imm;
    logic              bad_opcode;
    logic              bad_addr;
  } ibp_rec_t;

  // displacement bytes implied by the addressing byte alone
  function automatic logic [CNT_W-1:0] f_modrm_disp(input logic [1:0] md,
                                                    input logic [2:0] rm,
                                                    input logic a16);
    case (md)
      2'd0:    f_modrm_disp = a16 ? ((rm == 3'd6) ? CNT_W'(2) : CNT_W'(0))
                                  : ((rm == 3'd5) ? CNT_W'(4) : CNT_W'(0));
      2'd1:    f_modrm_disp = CNT_W'(1);
      2'd2:    f_modrm_disp = a16 ? CNT_W'(2) : CNT_W'(4);
      default: f_modrm_disp = CNT_W'(0);
    endcase
  endfunction

  function automatic logic f_sib_follows(input logic [1:0] md,
                                         input logic [2:0] rm,
                                         input logic a16);
    f_sib_follows = !a16 && (md != 2'd3) && (rm == 3'd4);
  endfunction

  // displacement bytes once a scale-index-base byte has been read
  function automatic logic [CNT_W-1:0] f_sib_disp(input logic [1:0] md,
                                                  input logic [2:0] base);
    case (md)
      2'd0:    f_sib_disp = (base == 3'd5) ? CNT_W'(4) : CNT_W'(0);
      2'd1:    f_sib_disp = CNT_W'(1);
      default: f_sib_disp = CNT_W'(4);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] f_imm_bytes(input logic w, input logic o16);
    f_imm_bytes = !w ? CNT_W'(1) : (o16 ? CNT_W'(2) : CNT_W'(4));
  endfunction

  function automatic sz_e f_opsize(input logic w, input logic o16);
    f_opsize = !w ? SZ8 : (o16 ? SZ16 : SZ32);
  endfunction

endpackage

// File: rtl/ibp_opc_dec.sv
module ibp_opc_dec
  import ibp_pkg::*;
(
  input  logic [7:0]       opc_byte,
  input  logic             pfx_o16,
  output logic             is_osz,
  output logic             is_asz,
  output logic             is_rm,
  output logic             is_movi,
  output logic [2:0]       movi_reg,
  output logic [CNT_W-1:0] movi_imm,
  output sz_e              opsize
);
  logic w_bit;

  assign is_osz   = (opc_byte == 8'h66);
  assign is_asz   = (opc_byte == 8'h67);
  assign is_rm    = (opc_byte[7:2] == 6'b100010) || (opc_byte[7:2] == 6'b000000);
  assign is_movi  = (opc_byte[7:4] == 4'hB);
  assign movi_reg = opc_byte[2:0];
  // unsupported opcodes report the full width chosen by the prefixes
  assign w_bit    = is_movi ? opc_byte[3] : (is_rm ? opc_byte[0] : 1'b1);
  assign movi_imm = f_imm_bytes(opc_byte[3], pfx_o16);
  assign opsize   = f_opsize(w_bit, pfx_o16);
endmodule

// File: rtl/ibp_addr_dec.sv
module ibp_addr_dec
  import ibp_pkg::*;
(
  input  logic [7:0]       cur_byte,
  input  logic             a16,
  input  logic [1:0]       held_mod,
  output logic             sib_next,
  output logic [CNT_W-1:0] modrm_disp,
  output logic [CNT_W-1:0] sib_disp,
  output logic             sib_undef
);
  // cur_byte read as an addressing byte
  assign sib_next   = f_sib_follows(cur_byte[7:6], cur_byte[2:0], a16);
  assign modrm_disp = f_modrm_disp(cur_byte[7:6], cur_byte[2:0], a16);
  // cur_byte read as a scale-index-base byte
  assign sib_disp   = f_sib_disp(held_mod, cur_byte[2:0]);
  assign sib_undef  = (cur_byte[5:3] == 3'd4) && (cur_byte[7:6] != 2'd0);
endmodule

// File: rtl/ibp_core.sv
module ibp_core
  import ibp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       in_ready,
  output logic       rec_valid,
  output ibp_rec_t   rec
);
  pstate_e          state, nstate;
  ibp_rec_t         cur, nxt;
  logic [CNT_W-1:0] cnt, ncnt;
  logic [1:0]       pos, npos;
  logic             pfx_o16, no16;

  logic             byte_fire;
  logic             rec_done;

  logic             is_osz, is_asz, is_rm, is_movi;
  logic [2:0]       movi_reg;
  logic [CNT_W-1:0] movi_imm;
  sz_e              opc_size;
  logic             sib_next, sib_undef;
  logic [CNT_W-1:0] modrm_disp, sib_disp;

  assign byte_fire = in_valid && in_ready;

  ibp_opc_dec u_opc (
    .opc_byte (in_byte),
    .pfx_o16  (pfx_o16),
    .is_osz   (is_osz),
    .is_asz   (is_asz),
    .is_rm    (is_rm),
    .is_movi  (is_movi),
    .movi_reg (movi_reg),
    .movi_imm (movi_imm),
    .opsize   (opc_size)
  );

  ibp_addr_dec u_addr (
    .cur_byte   (in_byte),
    .a16        (cur.addr16),
    .held_mod   (cur.mod),
    .sib_next   (sib_next),
    .modrm_disp (modrm_disp),
    .sib_disp   (sib_disp),
    .sib_undef  (sib_undef)
  );

  always_comb begin
    nxt      = cur;
    nstate   = state;
    ncnt     = cnt;
    npos     = pos;
    no16     = pfx_o16;
    rec_done = 1'b0;
    if (byte_fire) begin
      nxt.len = cur.len + LEN_W'(1);
      case (state)
        ST_HEAD: begin
          if (is_osz) begin
            no16 = 1'b1;
          end else if (is_asz) begin
            nxt.addr16 = 1'b1;
          end else if (is_rm) begin
            nxt.opcode    = in_byte;
            nxt.opsize    = opc_size;
            nxt.has_modrm = 1'b1;
            nstate        = ST_MODRM;
          end else if (is_movi) begin
            nxt.opcode    = in_byte;
            nxt.opsize    = opc_size;
            nxt.reg_f     = movi_reg;
            nxt.imm_bytes = movi_imm;
            ncnt          = movi_imm;
            npos          = 2'd0;
            nstate        = ST_IMM;
          end else begin
            nxt.opcode     = in_byte;
            nxt.opsize     = opc_size;
            nxt.bad_opcode = 1'b1;
            rec_done       = 1'b1;
          end
        end
        ST_MODRM: begin
          nxt.mod        = in_byte[7:6];
          nxt.reg_f      = in_byte[5:3];
          nxt.rm         = in_byte[2:0];
          nxt.disp_bytes = sib_next ? CNT_W'(0) : modrm_disp;
          ncnt           = modrm_disp;
          npos           = 2'd0;
          if (sib_next)                    nstate   = ST_SIB;
          else if (modrm_disp != CNT_W'(0)) nstate  = ST_DISP;
          else                             rec_done = 1'b1;
        end
        ST_SIB: begin
          nxt.has_sib    = 1'b1;
          nxt.scale      = in_byte[7:6];
          nxt.index      = in_byte[5:3];
          nxt.base       = in_byte[2:0];
          nxt.bad_addr   = sib_undef;
          nxt.disp_bytes = sib_disp;
          ncnt           = sib_disp;
          npos           = 2'd0;
          if (sib_disp != CNT_W'(0)) nstate   = ST_DISP;
          else                       rec_done = 1'b1;
        end
        ST_DISP: begin
          nxt.disp[{pos, 3'b000} +: 8] = in_byte;
          ncnt = cnt - CNT_W'(1);
          npos = pos + 2'd1;
          if (cnt == CNT_W'(1)) rec_done = 1'b1;
        end
        ST_IMM: begin
          nxt.imm[{pos, 3'b000} +: 8] = in_byte;
          ncnt = cnt - CNT_W'(1);
          npos = pos + 2'd1;
          if (cnt == CNT_W'(1)) rec_done = 1'b1;
        end
        default: nstate = ST_HEAD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_HEAD;
      cur       <= '0;
      cnt       <= '0;
      pos       <= '0;
      pfx_o16   <= 1'b0;
      in_ready  <= 1'b0;
      rec_valid <= 1'b0;
      rec       <= '0;
    end else begin
      in_ready  <= 1'b1;
      rec_valid <= rec_done;
      if (rec_done) begin
        rec     <= nxt;
        cur     <= '0;
        state   <= ST_HEAD;
        cnt     <= '0;
        pos     <= '0;
        pfx_o16 <= 1'b0;
      end else begin
        cur     <= nxt;
        state   <= nstate;
        cnt     <= ncnt;
        pos     <= npos;
        pfx_o16 <= no16;
      end
    end
  end

  // R11: a record only follows an accepted byte
  a_r11_pulse_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> $past(byte_fire));

  // R6: 16-bit addressing never carries a scale-index-base byte or 4-byte displacement
  a_r6_no_sib_in_16: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec.addr16) |-> (!rec.has_sib && rec.disp_bytes != CNT_W'(4)));

  // R7: the undefined-address flag needs a read scale-index-base byte
  a_r7_bad_addr_source: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec.bad_addr) |-> (rec.has_sib && rec.index == 3'd4 && rec.scale != 2'd0));

  // R8: an immediate comes only with the short form
  a_r8_imm_without_modrm: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec.imm_bytes != CNT_W'(0)) |-> !rec.has_modrm);

  // R10: an unsupported opcode closes the record with no field bytes
  a_r10_bad_opcode_bare: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec.bad_opcode) |->
      (!rec.has_modrm && rec.disp_bytes == CNT_W'(0) && rec.imm_bytes == CNT_W'(0)));

  // R1: while idle after a pulse, the parser stays ready
  a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_ready) |-> in_ready);
endmodule

// File: rtl/ibp_top.sv
module ibp_top
  import ibp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              in_ready,
  output logic              rec_valid,
  output logic [LEN_W-1:0]  rec_len,
  output logic [7:0]        rec_opcode,
  output logic [1:0]        rec_opsize,
  output logic              rec_addr16,
  output logic              rec_has_modrm,
  output logic [1:0]        rec_mod,
  output logic [2:0]        rec_reg,
  output logic [2:0]        rec_rm,
  output logic              rec_has_sib,
  output logic [1:0]        rec_scale,
  output logic [2:0]        rec_index,
  output logic [2:0]        rec_base,
  output logic [CNT_W-1:0]  rec_disp_bytes,
  output logic [DISP_W-1:0] rec_disp,
  output logic [CNT_W-1:0]  rec_imm_bytes,
  output logic [IMM_W-1:0]  rec_imm,
  output logic              rec_bad_opcode,
  output logic              rec_bad_addr
);
  ibp_rec_t rec;

  ibp_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .in_ready  (in_ready),
    .rec_valid (rec_valid),
    .rec       (rec)
  );

  assign rec_len        = rec.len;
  assign rec_opcode     = rec.opcode;
  assign rec_opsize     = rec.opsize;
  assign rec_addr16     = rec.addr16;
  assign rec_has_modrm  = rec.has_modrm;
  assign rec_mod        = rec.mod;
  assign rec_reg        = rec.reg_f;
  assign rec_rm         = rec.rm;
  assign rec_has_sib    = rec.has_sib;
  assign rec_scale      = rec.scale;
  assign rec_index      = rec.index;
  assign rec_base       = rec.base;
  assign rec_disp_bytes = rec.disp_bytes;
  assign rec_disp       = rec.disp;
  assign rec_imm_bytes  = rec.imm_bytes;
  assign rec_imm        = rec.imm;
  assign rec_bad_opcode = rec.bad_opcode;
  assign rec_bad_addr   = rec.bad_addr;
endmodule

// File: tb/ibp_top_tb.sv
`timescale 1ns/1ps
module ibp_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        in_ready, rec_valid;
  logic [4:0]  rec_len;
  logic [7:0]  rec_opcode;
  logic [1:0]  rec_opsize, rec_mod, rec_scale;
  logic        rec_addr16, rec_has_modrm, rec_has_sib, rec_bad_opcode, rec_bad_addr;
  logic [2:0]  rec_reg, rec_rm, rec_index, rec_base, rec_disp_bytes, rec_imm_bytes;
  logic [31:0] rec_disp, rec_imm;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ibp_top u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .rec_valid(rec_valid), .rec_len(rec_len),
    .rec_opcode(rec_opcode), .rec_opsize(rec_opsize), .rec_addr16(rec_addr16),
    .rec_has_modrm(rec_has_modrm), .rec_mod(rec_mod), .rec_reg(rec_reg),
    .rec_rm(rec_rm), .rec_has_sib(rec_has_sib), .rec_scale(rec_scale),
    .rec_index(rec_index), .rec_base(rec_base), .rec_disp_bytes(rec_disp_bytes),
    .rec_disp(rec_disp), .rec_imm_bytes(rec_imm_bytes), .rec_imm(rec_imm),
    .rec_bad_opcode(rec_bad_opcode), .rec_bad_addr(rec_bad_addr)
  );

  typedef struct packed {
    logic [4:0] len; logic [7:0] opc; logic [1:0] sz; logic a16; logic hm;
    logic [1:0] md; logic [2:0] rg; logic [2:0] rm; logic hs; logic [1:0] sc;
    logic [2:0] ix; logic [2:0] bs; logic [2:0] db; logic [31:0] disp;
    logic [2:0] ib; logic [31:0] imm; logic bo; logic ba;
  } exp_t;

  typedef struct packed { logic [63:0] b; logic [3:0] n; exp_t e; } vec_t;

  // bytes packed first byte in bits 7:0; sizes 0=8,1=16,2=32
  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{64'h4B048B66,       4'd4, '{4,8'h8B,1,0,1,0,0,4,1,1,1,3,0,32'h0,0,32'h0,0,0}},
    '{64'hC389,           4'd2, '{2,8'h89,2,0,1,3,0,3,0,0,0,0,0,32'h0,0,32'h0,0,0}},
    '{64'h1234810167,     4'd5, '{5,8'h01,2,1,1,2,0,1,0,0,0,0,2,32'h1234,0,32'h0,0,0}},
    '{64'h00000002B9,     4'd5, '{5,8'hB9,2,0,0,0,1,0,0,0,0,0,0,32'h0,4,32'h2,0,0}},
    '{64'h1234B966,       4'd4, '{4,8'hB9,1,0,0,0,1,0,0,0,0,0,0,32'h0,2,32'h1234,0,0}},
    '{64'h7FB0,           4'd2, '{2,8'hB0,0,0,0,0,0,0,0,0,0,0,0,32'h0,1,32'h7F,0,0}},
    '{64'hF04588,         4'd3, '{3,8'h88,0,0,1,1,0,5,0,0,0,0,1,32'hF0,0,32'h0,0,0}},
    '{64'h123456780503,   4'd6, '{6,8'h03,2,0,1,0,0,5,0,0,0,0,4,32'h12345678,0,32'h0,0,0}},
    '{64'hABCD068A67,     4'd5, '{5,8'h8A,0,1,1,0,0,6,0,0,0,0,2,32'hABCD,0,32'h0,0,0}},
    '{64'h112233442504_8B,4'd7, '{7,8'h8B,2,0,1,0,0,4,1,0,4,5,4,32'h11223344,0,32'h0,0,0}},
    '{64'h08A0448B,       4'd4, '{4,8'h8B,2,0,1,1,0,4,1,2,4,0,1,32'h08,0,32'h0,0,1}},
    '{64'h0F,             4'd1, '{1,8'h0F,2,0,0,0,0,0,0,0,0,0,0,32'h0,0,32'h0,1,0}},
    '{64'h2010848B6766,   4'd6, '{6,8'h8B,1,1,1,2,0,4,0,0,0,0,2,32'h2010,0,32'h0,0,0}},
    '{64'h00000001888C8B, 4'd7, '{7,8'h8B,2,0,1,2,1,4,1,2,1,0,4,32'h1,0,32'h0,0,0}},
    '{64'hFF66,           4'd2, '{2,8'hFF,1,0,0,0,0,0,0,0,0,0,0,32'h0,0,32'h0,1,0}},
    '{64'h05B366,         4'd3, '{3,8'hB3,0,0,0,0,3,0,0,0,0,0,0,32'h0,1,32'h05,0,0}},
    '{64'hC18B67,         4'd3, '{3,8'h8B,2,1,1,3,0,1,0,0,0,0,0,32'h0,0,32'h0,0,0}},
    '{64'h241C02,         4'd3, '{3,8'h02,0,0,1,0,3,4,1,0,4,4,0,32'h0,0,32'h0,0,0}},
    '{64'hC18B6667,       4'd4, '{4,8'h8B,1,1,1,3,0,1,0,0,0,0,0,32'h0,0,32'h0,0,0}}
  };

  function automatic string vreq(int i);
    case (i)
      0: return "R12"; 1: return "R3";  2: return "R6";  3: return "R9";
      4: return "R8";  5: return "R8";  6: return "R4";  7: return "R9";
      8: return "R6";  9: return "R5";  10: return "R7"; 11: return "R10";
      12: return "R2"; 13: return "R5"; 14: return "R10"; 15: return "R8";
      16: return "R6"; 17: return "R5"; default: return "R2";
    endcase
  endfunction

  function automatic exp_t actual();
    return '{rec_len, rec_opcode, rec_opsize, rec_addr16, rec_has_modrm, rec_mod,
             rec_reg, rec_rm, rec_has_sib, rec_scale, rec_index, rec_base,
             rec_disp_bytes, rec_disp, rec_imm_bytes, rec_imm, rec_bad_opcode,
             rec_bad_addr};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // feed one instruction; gap idle cycles carry a prefix byte that must be ignored
  task automatic send(input logic [63:0] b, input int n, input int gap,
                      output bit early);
    early = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i > 0 && rec_valid) early = 1;
      in_valid = 1'b1;
      in_byte  = b[8*i +: 8];
      if (i < n - 1) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          if (rec_valid) early = 1;
          in_valid = 1'b0;
          in_byte  = 8'h66;
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_byte  = 8'h00;
  endtask

  task automatic check_rec(input string req, input exp_t e);
    check(req, "rec_valid", 128'(rec_valid), 128'(1));
    check(req, "record", 128'(actual()), 128'(e));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit early;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "in_ready in reset", 128'(in_ready), 128'(0));
    check("R1", "rec_valid in reset", 128'(rec_valid), 128'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "in_ready after reset", 128'(in_ready), 128'(1));
    check("R1", "rec_valid after reset", 128'(rec_valid), 128'(0));

    for (int i = 0; i < NV; i++) begin
      send(VECS[i].b, int'(VECS[i].n), 0, early);
      check_rec(vreq(i), VECS[i].e);
      check("R11", "no early pulse", 128'(early), 128'(0));
    end

    // R11: idle cycles with prefix-valued garbage consume nothing
    send(VECS[7].b, int'(VECS[7].n), 2, early);
    check_rec("R11", VECS[7].e);
    check("R11", "no early pulse with gaps", 128'(early), 128'(0));

    // R11: back-to-back, next first byte accepted during the pulse
    send(VECS[1].b, 1, 0, early);
    @(negedge clk);
    in_valid = 1'b1; in_byte = VECS[1].b[15:8];
    @(negedge clk);
    check_rec("R11", VECS[1].e);
    in_valid = 1'b1; in_byte = VECS[5].b[7:0];
    @(negedge clk);
    check("R11", "single-cycle pulse", 128'(rec_valid), 128'(0));
    in_valid = 1'b1; in_byte = VECS[5].b[15:8];
    @(negedge clk);
    in_valid = 1'b0;
    check_rec("R11", VECS[5].e);

    // R1: reset in mid-instruction drops the partial prefix and opcode
    send(64'h8B66, 2, 0, early);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    send(VECS[1].b, int'(VECS[1].n), 0, early);
    check_rec("R1", VECS[1].e);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule